// File: doc/BRIEF.md
# Video Pixel Input Formatter

This block sits behind a parallel video input port and turns raw words from three 8-bit buses (luma bus Y, chroma bus C, side bus S) into a single per-pixel stream. Each output cycle carries up to three components and a valid strobe. Four input formats are handled. Two carry 4:2:2 YCrCb: a 16-bit single-data-rate form, and an 8-bit double-data-rate form in which both clock edges are sampled. Two carry 4:4:4 samples: YCrCb and RGB.

In the 4:2:2 formats the block tracks whether each chroma sample is blue-difference or red-difference. It also spots embedded timing reference codes (a full-scale word followed by two zero words and a status word). A detected code raises a one-cycle flag and exposes the status word. The pixels that carried the code are not marked valid.

The format and the DDR edge choice are static inputs. They are latched only on the first cycle after reset or during a synchronous clear, and both of those also reset the chroma phase and the code tracker.

Top module: `vpix_in_fmt`

## Requirements
- R1: While reset is held, and in the cycle after a cycle with `sync_clr` high, `pix_valid` and `ref_flag` are low. During reset all data outputs are zero.
- R2: Format 2'b00 (16-bit 4:2:2). The Y bus word sampled at rising edge k appears on `out_y_g` after rising edge k+1. The C bus word of the same edge is chroma. It goes to `out_cb_b` with `out_cr_r` = 0 when `out_cr_phase` is 0, and to `out_cr_r` with `out_cb_b` = 0 when `out_cr_phase` is 1.
- R3: Format 2'b01 (8-bit DDR 4:2:2). The Y bus is sampled at rising edge k and at the falling edge that follows, and the pair is output after rising edge k+1. With `luma_edge_sel` = 2'b11 the rising-edge word is luma and the falling-edge word is chroma. With any other value the roles are swapped. Chroma placement follows R2.
- R4: In 4:2:2 formats the chroma phase is 0 (Cb) for the first valid pixel after reset or clear. It toggles after every valid pixel, and it returns to 0 for the next pixel after a reference code is flagged.
- R5: Format 2'b10 (4:4:4 YCrCb). `out_y_g` takes the Y bus, `out_cr_r` takes the S bus and `out_cb_b` takes the C bus. `out_cr_phase` is 0.
- R6: Format 2'b11 (4:4:4 RGB). Green comes from the Y bus, red from the S bus and blue from the C bus. Every captured cycle is valid, and no reference code is flagged whatever the Y bus carries.
- R7: In the YCrCb formats, a luma-stream word of 8'hFF opens a window of four words: that word and the next three, in arrival order (rising then falling in DDR). Any cycle holding a window word is not valid. If the second and third window words are both 8'h00, `ref_flag` pulses for the cycle holding the fourth word and `ref_xy` takes that word. Otherwise no flag is raised.
- R8: Changes on `fmt_sel` and `luma_edge_sel` have no effect except on the first cycle after reset and in cycles with `sync_clr` high.
- R9: `pix_valid` and `ref_flag` are never high in the same cycle. Outside reference windows, every captured cycle yields a valid pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; both edges are used in DDR format |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_clr | input | 1 | Synchronous clear of phase state; loads format and edge select |
| fmt_sel | input | 2 | Input format: 00 16-bit 4:2:2, 01 DDR 8-bit 4:2:2, 10 4:4:4 YCrCb, 11 4:4:4 RGB |
| luma_edge_sel | input | 2 | DDR luma edge: 11 rising, other values falling |
| y_bus | input | W | Luma / green bus, shared luma-chroma bus in DDR |
| c_bus | input | W | Chroma / blue bus |
| s_bus | input | W | Red-difference / red bus |
| pix_valid | output | 1 | Output pixel valid strobe |
| out_y_g | output | W | Luma or green component |
| out_cb_b | output | W | Blue-difference or blue component |
| out_cr_r | output | W | Red-difference or red component |
| out_cr_phase | output | 1 | 1 when the 4:2:2 chroma sample is red-difference |
| ref_flag | output | 1 | One-cycle pulse on a detected timing reference code |
| ref_xy | output | W | Status word of the last detected reference code |

## Verification
The assertions watch cycle-local invariants on every clock: the valid strobe and the reference flag stay exclusive, a clear silences both outputs in the next cycle, the latched format and edge select stay unchanged between clears, the chroma phase reads Cb after a flagged code, the unused chroma output is zero, the phase stays at Cb in the 4:4:4 formats, and RGB never flags a code. Only the bench's scenarios can show that words land on the correct components for each format and edge setting, that DDR pairs form in the right order, and that a reference window straddling a pair boundary or carrying corrupted zero words is handled. The same applies to the ignored format and edge inputs between clears, since those inputs wander randomly against a reference model of the whole stream.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  typedef enum logic [1:0] {
    FMT_YC16  = 2'b00,
    FMT_DDR8  = 2'b01,
    FMT_YCC24 = 2'b10,
    FMT_RGB24 = 2'b11
  } fmt_e;

  // Edge select value that puts luma on the rising edge in DDR format
  localparam logic [1:0] LUMA_ON_RISE = 2'b11;

  // Reference window length counted after the leading full-scale word
  localparam int REF_TAIL = 3;

  function automatic logic fmt_is_422(fmt_e f);
    return (f == FMT_YC16) || (f == FMT_DDR8);
  endfunction

endpackage

// File: rtl/vpf_rst_sync.sv
module vpf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_n;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/vpf_capture.sv
module vpf_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] rise_y_o,
  output logic [W-1:0] fall_y_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] s_o,
  output logic         vld_o
);

  logic [W-1:0] rise_q, fall_q, c_q, s_q;
  logic         vld_q;
  logic         vld_n;

  always_comb begin
    vld_n = ~clr;
  end

  // Rising-edge bank: luma bus plus both side buses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      c_q    <= '0;
      s_q    <= '0;
      vld_q  <= 1'b0;
    end else begin
      rise_q <= y_i;
      c_q    <= c_i;
      s_q    <= s_i;
      vld_q  <= vld_n;
    end
  end

  // Falling-edge bank: second word of a DDR pair
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
    end else begin
      fall_q <= y_i;
    end
  end

  assign rise_y_o = rise_q;
  assign fall_y_o = fall_q;
  assign c_o      = c_q;
  assign s_o      = s_q;
  assign vld_o    = vld_q;

endmodule

// File: rtl/vpf_ref_track.sv
module vpf_ref_track #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         ref_en,
  input  logic         two_words,
  input  logic [W-1:0] word0,
  input  logic [W-1:0] word1,
  output logic         blk_o,
  output logic         det_o,
  output logic [W-1:0] xy_o
);

  import vpf_pkg::*;

  localparam int CW = $clog2(REF_TAIL + 1);
  localparam logic [CW-1:0] TAIL = CW'(REF_TAIL);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] win_q, win_n, win_v;
  logic          zok_q, zok_n, zok_v;
  logic          blk_v, det_v;
  logic [W-1:0]  xy_v;
  logic [W-1:0]  words [2];

  assign words[0] = word0;
  assign words[1] = word1;

  // Walk the words of this cycle in arrival order
  always_comb begin
    win_v = win_q;
    zok_v = zok_q;
    blk_v = 1'b0;
    det_v = 1'b0;
    xy_v  = '0;
    for (int k = 0; k < 2; k++) begin
      if ((k == 0) || two_words) begin
        if (win_v == '0) begin
          if (ref_en && (words[k] == {W{1'b1}})) begin
            win_v = TAIL;
            zok_v = 1'b1;
            blk_v = 1'b1;
          end
        end else begin
          blk_v = 1'b1;
          if (win_v == ONE) begin
            det_v = zok_v;
            xy_v  = words[k];
          end else begin
            zok_v = zok_v & (words[k] == '0);
          end
          win_v = win_v - ONE;
        end
      end
    end
  end

  always_comb begin
    if (clr) begin
      win_n = '0;
      zok_n = 1'b0;
    end else if (en) begin
      win_n = win_v;
      zok_n = zok_v;
    end else begin
      win_n = win_q;
      zok_n = zok_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      zok_q <= 1'b0;
    end else begin
      win_q <= win_n;
      zok_q <= zok_n;
    end
  end

  assign blk_o = en & blk_v;
  assign det_o = en & det_v;
  assign xy_o  = xy_v;

  // R7: the window position only moves on captured words
  p_win_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(win_q));

endmodule

// File: rtl/vpf_out_map.sv
module vpf_out_map
  import vpf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  fmt_e         fmt,
  input  logic         luma_rise,
  input  logic         vld,
  input  logic         blk,
  input  logic         det,
  input  logic [W-1:0] xy_i,
  input  logic [W-1:0] rise_y,
  input  logic [W-1:0] fall_y,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] s_i,
  output logic         valid_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] cb_o,
  output logic [W-1:0] cr_o,
  output logic         ph_o,
  output logic         trs_o,
  output logic [W-1:0] xy_o
);

  logic         is422;
  logic [W-1:0] luma, chroma;
  logic [W-1:0] y_n, cb_n, cr_n;
  logic         ph_n;
  logic         valid_n, trs_n, phase_n;

  logic         valid_q, trs_q, ph_q, phase_q;
  logic [W-1:0] y_q, cb_q, cr_q, xy_q;

  assign is422 = fmt_is_422(fmt);

  always_comb begin
    case (fmt)
      FMT_DDR8: begin
        luma   = luma_rise ? rise_y : fall_y;
        chroma = luma_rise ? fall_y : rise_y;
      end
      default: begin
        luma   = rise_y;
        chroma = c_i;
      end
    endcase
  end

  always_comb begin
    if (is422) begin
      y_n  = luma;
      cb_n = phase_q ? '0 : chroma;
      cr_n = phase_q ? chroma : '0;
      ph_n = phase_q;
    end else begin
      y_n  = rise_y;
      cb_n = c_i;
      cr_n = s_i;
      ph_n = 1'b0;
    end
  end

  always_comb begin
    valid_n = vld & ~blk & ~clr;
    trs_n   = det & ~clr;
    if (clr || trs_n) begin
      phase_n = 1'b0;
    end else if (valid_n && is422) begin
      phase_n = ~phase_q;
    end else begin
      phase_n = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      trs_q   <= 1'b0;
      phase_q <= 1'b0;
      y_q     <= '0;
      cb_q    <= '0;
      cr_q    <= '0;
      ph_q    <= 1'b0;
      xy_q    <= '0;
    end else begin
      valid_q <= valid_n;
      trs_q   <= trs_n;
      phase_q <= phase_n;
      if (valid_n) begin
        y_q  <= y_n;
        cb_q <= cb_n;
        cr_q <= cr_n;
        ph_q <= ph_n;
      end
      if (trs_n) begin
        xy_q <= xy_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign trs_o   = trs_q;
  assign y_o     = y_q;
  assign cb_o    = cb_q;
  assign cr_o    = cr_q;
  assign ph_o    = ph_q;
  assign xy_o    = xy_q;

  // R1: a clear silences the strobes on the following cycle
  p_clr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!valid_q && !trs_q));

  // R2: in a Cb slot the red-difference output carries zero
  p_cr_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && is422 && !ph_q) |-> (cr_q == '0));

  // R4: a flagged code leaves the chroma phase at Cb
  p_ref_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trs_q |-> !phase_q);

  // R5: 4:4:4 pixels never report a red-difference phase
  p_444_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !is422) |-> !ph_q);

  // R6: RGB never raises the reference flag
  p_rgb_no_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_RGB24) |-> !trs_q);

endmodule

// File: rtl/vpix_in_fmt.sv
module vpix_in_fmt #(
  parameter int W          = 8,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         sync_clr,
  input  logic [1:0]   fmt_sel,
  input  logic [1:0]   luma_edge_sel,
  input  logic [W-1:0] y_bus,
  input  logic [W-1:0] c_bus,
  input  logic [W-1:0] s_bus,
  output logic         pix_valid,
  output logic [W-1:0] out_y_g,
  output logic [W-1:0] out_cb_b,
  output logic [W-1:0] out_cr_r,
  output logic         out_cr_phase,
  output logic         ref_flag,
  output logic [W-1:0] ref_xy
);

  import vpf_pkg::*;

  logic         rst_n_s;
  logic         init_q;
  logic         clr_int;
  fmt_e         fmt_q, fmt_n;
  logic [1:0]   edge_q, edge_n;
  logic         ref_en, two_words, luma_rise;

  logic [W-1:0] rise_y, fall_y, c_q, s_q;
  logic         cap_vld;
  logic         blk, det;
  logic [W-1:0] xy_w;

  vpf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  // First cycle out of reset behaves as a clear so the settings load
  assign clr_int = sync_clr | ~init_q;

  always_comb begin
    fmt_n  = clr_int ? fmt_e'(fmt_sel) : fmt_q;
    edge_n = clr_int ? luma_edge_sel   : edge_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      init_q <= 1'b0;
      fmt_q  <= FMT_YC16;
      edge_q <= 2'b00;
    end else begin
      init_q <= 1'b1;
      fmt_q  <= fmt_n;
      edge_q <= edge_n;
    end
  end

  assign ref_en    = (fmt_q != FMT_RGB24);
  assign two_words = (fmt_q == FMT_DDR8);
  assign luma_rise = (edge_q == LUMA_ON_RISE);

  vpf_capture #(.W(W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (clr_int),
    .y_i      (y_bus),
    .c_i      (c_bus),
    .s_i      (s_bus),
    .rise_y_o (rise_y),
    .fall_y_o (fall_y),
    .c_o      (c_q),
    .s_o      (s_q),
    .vld_o    (cap_vld)
  );

  vpf_ref_track #(.W(W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr_int),
    .en        (cap_vld),
    .ref_en    (ref_en),
    .two_words (two_words),
    .word0     (rise_y),
    .word1     (fall_y),
    .blk_o     (blk),
    .det_o     (det),
    .xy_o      (xy_w)
  );

  vpf_out_map #(.W(W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr_int),
    .fmt       (fmt_q),
    .luma_rise (luma_rise),
    .vld       (cap_vld),
    .blk       (blk),
    .det       (det),
    .xy_i      (xy_w),
    .rise_y    (rise_y),
    .fall_y    (fall_y),
    .c_i       (c_q),
    .s_i       (s_q),
    .valid_o   (pix_valid),
    .y_o       (out_y_g),
    .cb_o      (out_cb_b),
    .cr_o      (out_cr_r),
    .ph_o      (out_cr_phase),
    .trs_o     (ref_flag),
    .xy_o      (ref_xy)
  );

  // R8: latched settings move only on a clear
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !clr_int |=> ($stable(fmt_q) && $stable(edge_q)));

  // R9: strobe and flag are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({pix_valid, ref_flag}));

endmodule

// File: tb/vpix_in_fmt_test.sv
module vpix_in_fmt_test;

  logic       clk;
  logic       arst_n;
  logic       sync_clr;
  logic [1:0] fmt_sel;
  logic [1:0] edge_sel;
  logic [7:0] y_bus, c_bus, s_bus;
  logic       pix_valid;
  logic [7:0] out_y_g, out_cb_b, out_cr_r;
  logic       out_cr_phase;
  logic       ref_flag;
  logic [7:0] ref_xy;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  vpix_in_fmt #(.W(8), .RST_STAGES(2)) uut (
    .clk           (clk),
    .arst_n        (arst_n),
    .sync_clr      (sync_clr),
    .fmt_sel       (fmt_sel),
    .luma_edge_sel (edge_sel),
    .y_bus         (y_bus),
    .c_bus         (c_bus),
    .s_bus         (s_bus),
    .pix_valid     (pix_valid),
    .out_y_g       (out_y_g),
    .out_cb_b      (out_cb_b),
    .out_cr_r      (out_cr_r),
    .out_cr_phase  (out_cr_phase),
    .ref_flag      (ref_flag),
    .ref_xy        (ref_xy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Reference model state
  logic [1:0] m_fmt, m_edge;
  int         m_win;
  bit         m_zok, m_phase;
  logic [7:0] e_y, e_cb, e_cr, m_xy;
  bit         e_ph, e_valid, e_trs;
  logic [7:0] p_ry, p_fy, p_c, p_s;
  bit         p_vld = 0;
  bit         first_after_clr;

  // Word stream generator with occasional reference codes
  logic [7:0] tbuf [4];
  int         tidx = 4;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_word(output logic [7:0] w);
    if (tidx < 4) begin
      w = tbuf[tidx];
      tidx++;
    end else if ($urandom % 18 == 0) begin
      tbuf[0] = 8'hFF;
      tbuf[1] = 8'h00;
      tbuf[2] = ($urandom % 5 == 0) ? 8'h5A : 8'h00;  // some corrupted codes
      tbuf[3] = 8'($urandom);
      w = 8'hFF;
      tidx = 1;
    end else begin
      w = 8'($urandom % 255);
    end
  endtask

  // Expected output after the edge that processes the previous cycle
  task automatic model_out(input bit clr_now);
    logic [7:0] w [2];
    int  n;
    bit  blk, det, is422, lr;
    logic [7:0] luma, chroma, xy;
    e_valid = 0;
    e_trs   = 0;
    if (!clr_now && p_vld) begin
      w[0] = p_ry;
      w[1] = p_fy;
      n = (m_fmt == 2'b01) ? 2 : 1;
      blk = 0; det = 0; xy = 8'h00;
      for (int k = 0; k < n; k++) begin
        if (m_win == 0) begin
          if (m_fmt != 2'b11 && w[k] == 8'hFF) begin
            m_win = 3; m_zok = 1; blk = 1;
          end
        end else begin
          blk = 1;
          if (m_win == 1) begin det = m_zok; xy = w[k]; end
          else m_zok = m_zok && (w[k] == 8'h00);
          m_win--;
        end
      end
      is422 = (m_fmt == 2'b00) || (m_fmt == 2'b01);
      lr = (m_edge == 2'b11);
      if (m_fmt == 2'b01) begin
        luma   = lr ? p_ry : p_fy;
        chroma = lr ? p_fy : p_ry;
      end else begin
        luma   = p_ry;
        chroma = p_c;
      end
      e_valid = !blk;
      e_trs   = det;
      if (det) begin
        m_xy = xy;
        m_phase = 0;
      end
      if (e_valid) begin
        if (is422) begin
          e_y  = luma;
          e_cb = m_phase ? 8'h00 : chroma;
          e_cr = m_phase ? chroma : 8'h00;
          e_ph = m_phase;
          m_phase = !m_phase;
        end else begin
          e_y  = p_ry;
          e_cb = p_c;
          e_cr = p_s;
          e_ph = 0;
        end
      end
    end
    if (clr_now) begin
      m_fmt = fmt_sel; m_edge = edge_sel;
      m_win = 0; m_zok = 0; m_phase = 0;
    end
  endtask

  function automatic string data_tag(input logic [1:0] f);
    case (f)
      2'b00:   return "R2/R8";
      2'b01:   return "R3/R8";
      2'b10:   return "R5/R8";
      default: return "R6/R8";
    endcase
  endfunction

  task automatic run_cycle(input bit clr, input logic [7:0] ry, input logic [7:0] fy,
                           input logic [7:0] c, input logic [7:0] s,
                           input logic [1:0] f, input logic [1:0] e);
    logic [1:0] fmt_used;
    @(negedge clk); #1;
    sync_clr = clr; y_bus = ry; c_bus = c; s_bus = s; fmt_sel = f; edge_sel = e;
    @(posedge clk); #1;
    fmt_used = m_fmt;
    model_out(clr);
    if (clr || first_after_clr) begin
      chk("R1 valid after clear", {7'd0, pix_valid}, {7'd0, e_valid});
      chk("R1 flag after clear", {7'd0, ref_flag}, {7'd0, e_trs});
    end else begin
      chk("R9 valid strobe", {7'd0, pix_valid}, {7'd0, e_valid});
      chk("R7 reference flag", {7'd0, ref_flag}, {7'd0, e_trs});
    end
    first_after_clr = clr;
    if (e_valid) begin
      chk(data_tag(fmt_used), out_y_g, e_y);
      chk(data_tag(fmt_used), out_cb_b, e_cb);
      chk(data_tag(fmt_used), out_cr_r, e_cr);
      chk("R4 chroma phase", {7'd0, out_cr_phase}, {7'd0, e_ph});
    end
    if (e_trs) chk("R7 status word", ref_xy, m_xy);
    y_bus = fy;
    p_ry = ry; p_fy = fy; p_c = c; p_s = s; p_vld = !clr;
  endtask

  // One segment: clear with the chosen settings, then random traffic while
  // the setting inputs wander (R8: they must be ignored)
  task automatic run_seg(input logic [1:0] f, input logic [1:0] e, input int ncyc);
    logic [7:0] a, b;
    tidx = 4;
    run_cycle(1, 8'h00, 8'h00, 8'h00, 8'h00, f, e);
    for (int i = 0; i < ncyc; i++) begin
      next_word(a);
      if (f == 2'b01) next_word(b);
      else b = a;
      run_cycle(0, a, b, 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    arst_n = 0; sync_clr = 0; fmt_sel = 0; edge_sel = 0;
    y_bus = 8'h37; c_bus = 8'h91; s_bus = 8'hC4;
    first_after_clr = 0;
    repeat (4) @(posedge clk);
    #1;
    // R1: state while reset is held
    chk("R1 reset valid", {7'd0, pix_valid}, 8'd0);
    chk("R1 reset flag", {7'd0, ref_flag}, 8'd0);
    chk("R1 reset luma", out_y_g, 8'd0);
    chk("R1 reset cb", out_cb_b, 8'd0);
    chk("R1 reset cr", out_cr_r, 8'd0);
    chk("R1 reset xy", ref_xy, 8'd0);
    arst_n = 1;
    repeat (4) @(posedge clk);

    // Directed: DDR luma-on-rise, clean code aligned to pairs
    run_cycle(1, 8'h00, 8'h00, 8'h00, 8'h00, 2'b01, 2'b11);
    run_cycle(0, 8'h40, 8'h80, 8'h00, 8'h00, 2'b00, 2'b00);
    run_cycle(0, 8'h41, 8'h90, 8'h00, 8'h00, 2'b10, 2'b01);
    run_cycle(0, 8'hFF, 8'h00, 8'h00, 8'h00, 2'b11, 2'b00);
    run_cycle(0, 8'h00, 8'hB6, 8'h00, 8'h00, 2'b00, 2'b00);
    run_cycle(0, 8'h42, 8'hA0, 8'h00, 8'h00, 2'b00, 2'b00);
    run_cycle(0, 8'h43, 8'hA1, 8'h00, 8'h00, 2'b00, 2'b00);
    // Directed: code straddling a DDR pair boundary, luma on falling edge
    run_cycle(1, 8'h00, 8'h00, 8'h00, 8'h00, 2'b01, 2'b00);
    run_cycle(0, 8'h20, 8'hFF, 8'h00, 8'h00, 2'b00, 2'b00);
    run_cycle(0, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 2'b00);
    run_cycle(0, 8'h9D, 8'h30, 8'h00, 8'h00, 2'b00, 2'b00);
    run_cycle(0, 8'h21, 8'h31, 8'h00, 8'h00, 2'b00, 2'b00);
    // Directed: RGB sees a code-like pattern and must pass it as pixels
    run_cycle(1, 8'h00, 8'h00, 8'h00, 8'h00, 2'b11, 2'b00);
    run_cycle(0, 8'hFF, 8'hFF, 8'h11, 8'h22, 2'b00, 2'b00);
    run_cycle(0, 8'h00, 8'h00, 8'h33, 8'h44, 2'b01, 2'b00);
    run_cycle(0, 8'h00, 8'h00, 8'h55, 8'h66, 2'b10, 2'b00);
    run_cycle(0, 8'hEC, 8'hEC, 8'h77, 8'h88, 2'b00, 2'b00);

    // Constrained random segments over every format and edge setting
    run_seg(2'b00, 2'b00, 500);
    run_seg(2'b01, 2'b00, 500);
    run_seg(2'b01, 2'b11, 500);
    run_seg(2'b01, 2'b10, 300);
    run_seg(2'b10, 2'b00, 500);
    run_seg(2'b11, 2'b00, 400);
    run_seg(2'b00, 2'b11, 300);
    run_seg(2'b01, 2'b11, 3);
    run_seg(2'b10, 2'b01, 300);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule